// File: doc/BRIEF.md
# HDLC Receive Frame Checker

This block takes a serial HDLC bitstream, one bit for each cycle in which a bit-enable strobe is high. It looks for flag octets to find where frames begin and end. It deletes the zeros the transmitter inserted after runs of five ones, and packs the remaining data bits into octets, least significant bit first. While a frame is open, it counts the data bits, runs a bit-serial CRC-16 over them and compares the growing octet count against a programmable ceiling.

Octets leave the block as a byte stream with a valid strobe. The final stored octet of each frame carries a last marker. In that same cycle a one-cycle frame-done pulse presents a five-bit status word and the frame length in octets. A separate level output shows that the line is idle.

Surrounding logic uses the block in front of a buffer writer. The writer stores the byte stream, and when frame-done arrives it reads the status word to decide how to treat the buffer.

Top module: `hdlcRxChecker`

## Requirements
- R1: The pattern 01111110 in the raw stream is a flag. A flag that follows one or more data bits closes the frame, and every flag opens a new one. Consecutive flags with no data bits between them produce no frame-done pulse.
- R2: Inside a frame, a 0 bit that follows five consecutive 1 bits is deleted and does not count as data.
- R3: Data octets are assembled least significant bit first. Each octet is output with dataValid high for one cycle, and only the final stored octet of a frame has dataLast high. That final octet appears in the same cycle as frameDone. After reset, dataValid, dataLast, frameDone and idleLine are all low.
- R4: The CRC-16 uses reflected polynomial 0x8408 and starts from 0xFFFF. It runs over every data bit, including the two received check octets, which are also output as data. Status bit 0 (CRC error) is set when the final register value differs from 0xF0B8.
- R5: frameLen is the number of whole octets between the opening flag and the closing flag, counting octets that were discarded.
- R6: Status bit 2 (non-octet) is set when the data bit count is not a multiple of eight. This includes a frame of a single bit.
- R7: Octets beyond maxLen are not output, but reception continues. The next flag closes the frame with status bit 3 (length violation) set.
- R8: Seven consecutive 1 bits after at least one data bit close the frame at once. The status word is then 0x02 (status bit 1, abort), with bit 3 added if the ceiling had already been passed.
- R9: Seven or more 1 bits after a flag and before any data bit produce no frame-done pulse and no abort status, and the next frame is received normally.
- R10: When ssMode is high, status bit 4 (short frame) is set for frames of fewer than 5 octets. When ssMode is low, it stays clear.
- R11: idleLine rises once IDLE_ONES consecutive 1 bits have been received, and falls at the next 0 bit.
- R12: rxBit has no effect in cycles where bitEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitEn | input | 1 | Qualifies rxBit for this cycle |
| rxBit | input | 1 | Serial receive bit |
| maxLen | input | LEN_W | Octet ceiling per frame |
| ssMode | input | 1 | Enables the short-frame status bit |
| dataByte | output | 8 | Received octet |
| dataValid | output | 1 | dataByte is valid this cycle |
| dataLast | output | 1 | dataByte is the last stored octet of the frame |
| frameDone | output | 1 | One-cycle pulse at frame close |
| frameStatus | output | 5 | {short, length, non-octet, abort, CRC} at frame close |
| frameLen | output | LEN_W | Octet count of the closed frame |
| idleLine | output | 1 | Line has been at 1 for IDLE_ONES bits or more |

## Verification
The bench builds the block with LEN_W at 8 and IDLE_ONES at 15. An 8-bit ceiling lets a ceiling of 4 octets be crossed by a frame only a few octets long, so the discard-and-continue path is reached quickly. The idle threshold of 15 sits well above the 7-bit abort run, so a single run of ones can show the abort closing the frame first and the idle level rising later. Bit-enable gaps with the inverted bit on the line are present on every transmitted bit.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam logic [15:0] CRC_INIT    = 16'hFFFF;
  localparam logic [15:0] CRC_POLY    = 16'h8408;
  localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
  localparam logic [7:0]  FLAG_BYTE   = 8'h7E;

  // Status word, bit 4 down to bit 0
  typedef struct packed {
    logic shortFrame;
    logic lenViol;
    logic nonOctet;
    logic abort;
    logic crcErr;
  } rxStatusT;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeBit;
    logic storeByte;
    logic flushLast;
    logic frameStart;
  } rxStrobeT;

  function automatic logic [15:0] crcStep(input logic [15:0] crc, input logic bitIn);
    logic fb;
    fb = crc[0] ^ bitIn;
    crcStep = (crc >> 1) ^ (fb ? CRC_POLY : 16'h0000);
  endfunction

endpackage

// File: rtl/hdlcRxDatapath.sv
module hdlcRxDatapath
  import hdlc_rx_pkg::*;
#(
  parameter int IDLE_ONES = 15
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     bitEn,
  input  logic     rxBit,
  input  rxStrobeT strb,
  output logic     flagSeen,
  output logic     abortRun,
  output logic     exitData,
  output logic     crcGoodNext,
  output logic     idleLine,
  output logic [7:0] dataByte,
  output logic     dataValid,
  output logic     dataLast
);

  localparam int RUN_W = $clog2(IDLE_ONES + 1);
  localparam logic [RUN_W-1:0] RUN_MAX   = RUN_W'(IDLE_ONES);
  localparam logic [RUN_W-1:0] RUN_STUFF = RUN_W'(5);
  localparam logic [RUN_W-1:0] RUN_ABORT = RUN_W'(6);

  logic [7:0]       win, winValid, winStuff;
  logic [7:0]       nextWin;
  logic [RUN_W-1:0] onesRun, onesNext;
  logic [15:0]      crcReg, crcNext;
  logic [7:0]       shiftByte, newByte, holdByte;
  logic             holdValid;
  logic             stuffIn;

  // Raw 8-bit window: newest bit enters at the top, the oldest leaves at bit 0
  assign nextWin  = {rxBit, win[7:1]};
  assign flagSeen = bitEn && (nextWin == FLAG_BYTE);
  assign stuffIn  = !rxBit && (onesRun == RUN_STUFF);
  assign abortRun = bitEn && rxBit && (onesRun == RUN_ABORT);
  assign exitData = bitEn && winValid[0] && !winStuff[0];

  always_comb begin
    if (!rxBit)                onesNext = '0;
    else if (onesRun == RUN_MAX) onesNext = onesRun;
    else                       onesNext = onesRun + 1'b1;
  end

  assign crcNext     = strb.takeBit ? crcStep(crcReg, win[0]) : crcReg;
  assign crcGoodNext = (crcNext == CRC_RESIDUE);
  assign newByte     = {win[0], shiftByte[7:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      win      <= '0;
      winValid <= '0;
      winStuff <= '0;
      onesRun  <= '0;
      idleLine <= 1'b0;
    end else if (bitEn) begin
      win      <= nextWin;
      winValid <= flagSeen ? 8'h00 : {1'b1, winValid[7:1]};
      winStuff <= {stuffIn, winStuff[7:1]};
      onesRun  <= onesNext;
      idleLine <= (onesNext == RUN_MAX);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg    <= CRC_INIT;
      shiftByte <= '0;
    end else begin
      crcReg <= strb.frameStart ? CRC_INIT : crcNext;
      if (strb.takeBit) shiftByte <= newByte;
    end
  end

  // One-octet hold stage so the last octet can be marked at frame close
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdByte  <= '0;
      holdValid <= 1'b0;
      dataByte  <= '0;
      dataValid <= 1'b0;
      dataLast  <= 1'b0;
    end else begin
      dataValid <= 1'b0;
      dataLast  <= 1'b0;
      if (strb.storeByte) begin
        if (holdValid) begin
          dataValid <= 1'b1;
          dataByte  <= holdByte;
        end
        holdByte  <= newByte;
        holdValid <= 1'b1;
      end else if (strb.flushLast && holdValid) begin
        dataValid <= 1'b1;
        dataLast  <= 1'b1;
        dataByte  <= holdByte;
        holdValid <= 1'b0;
      end
    end
  end

  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rstN)
    dataLast |-> dataValid);  // R3
  AST_STORE_FLUSH_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeByte |-> !strb.flushLast);  // R3

endmodule

// File: rtl/hdlcRxControl.sv
module hdlcRxControl
  import hdlc_rx_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flagSeen,
  input  logic             abortRun,
  input  logic             exitData,
  input  logic             crcGoodNext,
  input  logic [LEN_W-1:0] maxLen,
  input  logic             ssMode,
  output rxStrobeT         strb,
  output logic             frameDone,
  output rxStatusT         frameStatus,
  output logic [LEN_W-1:0] frameLen
);

  localparam int CNT_W = LEN_W + 3;
  localparam logic [LEN_W-1:0] SHORT_LIM = LEN_W'(5);

  logic             inFrame, lgFlag, lgNext;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic [LEN_W-1:0] octNow, lenQ;
  logic             dataEv, octDone, overMax, hasData;
  logic             closeFlag, closeAbort, closeQ;
  rxStatusT         statQ;

  assign dataEv  = inFrame && exitData;
  assign cntNext = (dataEv && (bitCnt != '1)) ? bitCnt + 1'b1 : bitCnt;
  assign octNow  = cntNext[CNT_W-1:3];
  assign octDone = dataEv && (cntNext[2:0] == 3'd0);
  assign overMax = octNow > maxLen;
  assign lgNext  = lgFlag || (octDone && overMax);
  assign hasData = inFrame && (cntNext != '0);

  assign closeFlag  = flagSeen && hasData;
  assign closeAbort = abortRun && hasData;

  always_comb begin
    strb            = '0;
    strb.takeBit    = dataEv;
    strb.storeByte  = octDone && !overMax;
    strb.flushLast  = closeQ;
    strb.frameStart = flagSeen;
  end

  // Frame state: open after any flag, dropped on a run of seven ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      bitCnt  <= '0;
      lgFlag  <= 1'b0;
    end else if (flagSeen) begin
      inFrame <= 1'b1;
      bitCnt  <= '0;
      lgFlag  <= 1'b0;
    end else if (abortRun) begin
      inFrame <= 1'b0;
      bitCnt  <= '0;
      lgFlag  <= 1'b0;
    end else begin
      bitCnt <= cntNext;
      lgFlag <= lgNext;
    end
  end

  // Close stage: capture status, then present it with the last octet
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      closeQ      <= 1'b0;
      statQ       <= '0;
      lenQ        <= '0;
      frameDone   <= 1'b0;
      frameStatus <= '0;
      frameLen    <= '0;
    end else begin
      closeQ <= closeFlag || closeAbort;
      if (closeFlag) begin
        statQ.shortFrame <= ssMode && (octNow < SHORT_LIM);
        statQ.lenViol    <= lgNext;
        statQ.nonOctet   <= (cntNext[2:0] != 3'd0);
        statQ.abort      <= 1'b0;
        statQ.crcErr     <= !crcGoodNext;
        lenQ             <= octNow;
      end else if (closeAbort) begin
        statQ.shortFrame <= 1'b0;
        statQ.lenViol    <= lgNext;
        statQ.nonOctet   <= 1'b0;
        statQ.abort      <= 1'b1;
        statQ.crcErr     <= 1'b0;
        lenQ             <= octNow;
      end
      frameDone <= closeQ;
      if (closeQ) begin
        frameStatus <= statQ;
        frameLen    <= lenQ;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);  // R1
  AST_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && frameStatus.abort) |-> !(frameStatus.nonOctet || frameStatus.crcErr || frameStatus.shortFrame));  // R8
  AST_SHORT_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && frameStatus.shortFrame) |-> (frameLen < SHORT_LIM));  // R10
  AST_NO_STORE_PAST_MAX: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeByte |-> !lgFlag);  // R7

endmodule

// File: rtl/hdlcRxChecker.sv
module hdlcRxChecker
  import hdlc_rx_pkg::*;
#(
  parameter int LEN_W     = 12,
  parameter int IDLE_ONES = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             rxBit,
  input  logic [LEN_W-1:0] maxLen,
  input  logic             ssMode,
  output logic [7:0]       dataByte,
  output logic             dataValid,
  output logic             dataLast,
  output logic             frameDone,
  output logic [4:0]       frameStatus,
  output logic [LEN_W-1:0] frameLen,
  output logic             idleLine
);

  rxStrobeT strb;
  rxStatusT statusW;
  logic     flagSeen, abortRun, exitData, crcGoodNext;

  hdlcRxDatapath #(.IDLE_ONES(IDLE_ONES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .bitEn      (bitEn),
    .rxBit      (rxBit),
    .strb       (strb),
    .flagSeen   (flagSeen),
    .abortRun   (abortRun),
    .exitData   (exitData),
    .crcGoodNext(crcGoodNext),
    .idleLine   (idleLine),
    .dataByte   (dataByte),
    .dataValid  (dataValid),
    .dataLast   (dataLast)
  );

  hdlcRxControl #(.LEN_W(LEN_W)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .flagSeen   (flagSeen),
    .abortRun   (abortRun),
    .exitData   (exitData),
    .crcGoodNext(crcGoodNext),
    .maxLen     (maxLen),
    .ssMode     (ssMode),
    .strb       (strb),
    .frameDone  (frameDone),
    .frameStatus(statusW),
    .frameLen   (frameLen)
  );

  assign frameStatus = statusW;

endmodule

// File: tb/hdlcRxChecker_tb.sv
module hdlcRxChecker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 8;
  localparam int NV = 4;

  // Table: data bytes (byte 0 in bits 7:0), count, FCS mode (1 good, 2 bad),
  // ceiling, short mode, expected status, length and bytes output
  localparam logic [47:0] V_DATA [NV] = '{48'h0000_00FF_7E11, 48'h0000_C300_A53F,
                                          48'h0000_0000_0281, 48'h0605_0403_0201};
  localparam int V_N    [NV] = '{3, 4, 2, 6};
  localparam int V_FCS  [NV] = '{1, 2, 1, 1};
  localparam int V_MAX  [NV] = '{16, 16, 16, 4};
  localparam int V_SS   [NV] = '{0, 1, 1, 0};
  localparam int V_STAT [NV] = '{0, 1, 16, 8};
  localparam int V_LEN  [NV] = '{5, 6, 4, 8};
  localparam int V_OUT  [NV] = '{5, 6, 4, 4};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic rxBit = 1'b0;
  logic [LEN_W-1:0] maxLen = 8'd16;
  logic ssMode = 1'b0;
  logic [7:0] dataByte;
  logic dataValid, dataLast, frameDone, idleLine;
  logic [4:0] frameStatus;
  logic [LEN_W-1:0] frameLen;

  int nChecks = 0;
  int nFails = 0;
  int txOnes = 0;
  int capN = 0;
  int doneCnt = 0;
  int lastStat = 0;
  int lastLen = 0;
  logic [7:0] capByte [0:63];
  logic       capLast [0:63];
  logic [7:0] txBuf [0:15];
  int txN = 0;
  logic [15:0] bcrc;
  bit finished = 1'b0;

  hdlcRxChecker #(.LEN_W(LEN_W), .IDLE_ONES(15)) u_dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit), .maxLen(maxLen),
    .ssMode(ssMode), .dataByte(dataByte), .dataValid(dataValid), .dataLast(dataLast),
    .frameDone(frameDone), .frameStatus(frameStatus), .frameLen(frameLen),
    .idleLine(idleLine)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (dataValid && capN < 64) begin
      capByte[capN] = dataByte;
      capLast[capN] = dataLast;
      capN = capN + 1;
    end
    if (frameDone) begin
      doneCnt = doneCnt + 1;
      lastStat = int'(frameStatus);
      lastLen = int'(frameLen);
    end
  end

  function automatic logic [15:0] modelCrc(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    modelCrc = (c >> 1) ^ (fb ? 16'h8408 : 16'h0000);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks = nChecks + 1;
    if (!ok) begin
      nFails = nFails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Each bit is qualified for one cycle, then a gap with the inverse on the line (R12)
  task automatic sendRaw(input logic b);
    @(negedge clk);
    rxBit = b;
    bitEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0;
    rxBit = ~b;
  endtask

  task automatic sendFlag();
    sendRaw(1'b0);
    for (int i = 0; i < 6; i++) sendRaw(1'b1);
    sendRaw(1'b0);
    txOnes = 0;
  endtask

  task automatic sendData(input logic b);
    sendRaw(b);
    bcrc = modelCrc(bcrc, b);
    if (b) begin
      txOnes = txOnes + 1;
      if (txOnes == 5) begin
        sendRaw(1'b0);
        txOnes = 0;
      end
    end else begin
      txOnes = 0;
    end
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendData(v[i]);
  endtask

  task automatic waitClose();
    repeat (6) @(negedge clk);
  endtask

  // Sends txBuf[0..txN-1] plus FCS, mode 1 good, 2 corrupted; returns full octet list in txBuf
  task automatic sendFrame(input int fcsMode);
    logic [15:0] fcs;
    int n;
    n = txN;
    bcrc = 16'hFFFF;
    sendFlag();
    for (int i = 0; i < n; i++) sendByte(txBuf[i]);
    fcs = ~bcrc;
    if (fcsMode == 2) fcs = fcs ^ 16'h0001;
    txBuf[n] = fcs[7:0];
    txBuf[n+1] = fcs[15:8];
    sendByte(fcs[7:0]);
    sendByte(fcs[15:8]);
    sendFlag();
    waitClose();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChecks = nChecks + 1;
      nFails = nFails + 1;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // Reset state (R3)
    check(dataValid == 1'b0 && dataLast == 1'b0 && frameDone == 1'b0, "R3 reset outputs",
          int'({dataValid, dataLast, frameDone}), 0);
    check(idleLine == 1'b0, "R11 reset idle", int'(idleLine), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Table-driven frames: R2 R3 R4 R5 R7 R10
    for (int v = 0; v < NV; v++) begin
      maxLen = LEN_W'(V_MAX[v]);
      ssMode = (V_SS[v] != 0);
      txN = V_N[v];
      for (int i = 0; i < V_N[v]; i++) txBuf[i] = V_DATA[v][8*i +: 8];
      capN = 0;
      base = doneCnt;
      sendFrame(V_FCS[v]);
      check(doneCnt == base + 1, "R1 one close per frame", doneCnt - base, 1);
      check(lastStat == V_STAT[v], "R4/R7/R10 status", lastStat, V_STAT[v]);
      check(lastLen == V_LEN[v], "R5 length", lastLen, V_LEN[v]);
      check(capN == V_OUT[v], "R7 octets output", capN, V_OUT[v]);
      for (int i = 0; i < V_OUT[v] && i < capN; i++) begin
        check(capByte[i] == txBuf[i], "R2 R3 R4 octet value", int'(capByte[i]), int'(txBuf[i]));
        check(capLast[i] == (i == V_OUT[v] - 1), "R3 last marker", int'(capLast[i]),
              int'(i == V_OUT[v] - 1));
      end
    end
    maxLen = 8'd16;
    ssMode = 1'b0;

    // Flag, one bit, flag (R6)
    capN = 0;
    base = doneCnt;
    sendFlag();
    sendData(1'b1);
    sendFlag();
    waitClose();
    check(doneCnt == base + 1, "R6 single-bit frame closes", doneCnt - base, 1);
    check(lastStat[2] == 1'b1, "R6 single-bit non-octet", lastStat, 4);
    check(lastLen == 0, "R5 single-bit length", lastLen, 0);
    check(capN == 0, "R3 no octet for one bit", capN, 0);

    // Two octets and three bits (R6)
    base = doneCnt;
    sendFlag();
    sendByte(8'h0F);
    sendByte(8'h33);
    sendData(1'b1);
    sendData(1'b0);
    sendData(1'b1);
    sendFlag();
    waitClose();
    check(doneCnt == base + 1 && lastStat[2] == 1'b1, "R6 non-octet", lastStat, 4);
    check(lastLen == 2, "R5 non-octet length", lastLen, 2);

    // Back-to-back flags, no data (R1)
    base = doneCnt;
    sendFlag();
    sendFlag();
    sendFlag();
    waitClose();
    check(doneCnt == base, "R1 idle flags", doneCnt - base, 0);

    // Abort inside a frame (R8), then idle (R11)
    base = doneCnt;
    sendFlag();
    sendByte(8'hA5);
    sendByte(8'h5A);
    for (int i = 0; i < 8; i++) sendRaw(1'b1);
    waitClose();
    check(doneCnt == base + 1, "R8 abort closes frame", doneCnt - base, 1);
    check(lastStat == 2, "R8 abort status", lastStat, 2);
    check(idleLine == 1'b0, "R11 not idle yet", int'(idleLine), 0);
    for (int i = 0; i < 8; i++) sendRaw(1'b1);
    @(negedge clk);
    check(idleLine == 1'b1, "R11 idle after run", int'(idleLine), 1);
    sendRaw(1'b0);
    @(negedge clk);
    check(idleLine == 1'b0, "R11 idle clears", int'(idleLine), 0);

    // Ones between frames (R9)
    base = doneCnt;
    sendFlag();
    for (int i = 0; i < 10; i++) sendRaw(1'b1);
    waitClose();
    check(doneCnt == base, "R9 no close between frames", doneCnt - base, 0);
    txN = 1;
    txBuf[0] = 8'h42;
    capN = 0;
    sendFrame(1);
    check(doneCnt == base + 1 && lastStat == 0, "R9 next frame clean", lastStat, 0);

    // Ones on the line with bitEn low inside an open frame (R12)
    base = doneCnt;
    sendFlag();
    @(negedge clk);
    rxBit = 1'b1;
    repeat (24) @(negedge clk);
    rxBit = 1'b0;
    check(doneCnt == base && idleLine == 1'b0, "R12 ungated ones ignored", doneCnt - base, 0);
    bcrc = 16'hFFFF;
    sendByte(8'h99);
    begin
      logic [15:0] f;
      f = ~bcrc;
      sendByte(f[7:0]);
      sendByte(f[15:8]);
    end
    sendFlag();
    waitClose();
    check(doneCnt == base + 1 && lastStat == 0, "R12 frame unaffected", lastStat, 0);
    check(lastLen == 3, "R12 length", lastLen, 3);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule